// File: doc/BRIEF.md
# Planner Host Register Bank

This block sits between a host processor and a grid path-planning engine. The host uses a plain 32-bit address/data bus with a write strobe and a read strobe, and read data comes back on the next clock. Through this bus the host loads a 16x16 occupancy grid as sixteen row words and writes one packed word that holds the start cell and the goal cell. It then writes 1 to a launch register. The bank sends the engine a single-cycle launch pulse. It holds the grid and endpoints steady while the engine runs, and when the engine reports completion it latches the resulting path word and raises a finished flag.

The register layout is fixed. Offset 0x00 is launch, write-only. Offset 0x04 is finished, read-only. Offset 0x08 is the endpoints word, write-only. Offset 0x0C is the path result, read-only. Offsets 0x10 to 0x4C hold the grid rows, and row k is at 0x10 + 4k. The engine sees the whole grid as one 256-bit vector, with row k in bits [16k+15:16k].

Top module: `plan_regbank`

## Requirements
- R1: After reset, reads of offsets 0x04 and 0x0C return 0. The grid output, the endpoints output and the launch pulse are all 0.
- R2: If the block is idle, a write of 1 in bit 0 to offset 0x00 drives `eng_launch` high for exactly one cycle, the cycle after the write, and the block becomes busy. A write of 0 has no effect.
- R3: While busy, a read of 0x04 returns 0. Writing 1 to 0x00 while busy produces no further launch pulse.
- R4: In the cycle that `eng_done` is high while busy, the block stores `eng_path` into the path register and sets finished. From the next cycle, a read of 0x0C returns that value and a read of 0x04 returns 1. Later `eng_path` changes do not alter the stored value.
- R5: When idle, a write to offset 0x10+4k stores wdata[15:0] as grid row k. The row appears on `eng_grid[16k+15:16k]` in the cycle after the write. Bits [31:16] of the write are discarded.
- R6: When idle, a write to 0x08 stores wdata[15:0] on `eng_ends`. The start x is in [15:12], start y in [11:8], goal x in [7:4] and goal y in [3:0].
- R7: While busy, writes to grid rows and to 0x08 leave `eng_grid` and `eng_ends` unchanged.
- R8: Reads of the write-only offsets (0x00, 0x08, 0x10 to 0x4C) and of unmapped offsets return 0. Writes to 0x04, 0x0C or unmapped offsets change no output and no readable value.
- R9: `rdata` is registered. It presents the value selected by the read issued in the previous cycle, and it is 0 in a cycle with no read the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Byte offset of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, one cycle after rd_en |
| eng_launch | output | 1 | One-cycle launch pulse to the engine |
| eng_grid | output | 256 | Occupancy grid, row k in bits [16k+15:16k] |
| eng_ends | output | 16 | Packed start and goal coordinates |
| eng_done | input | 1 | Engine completion strobe |
| eng_path | input | 32 | Engine path result |

## Verification
A corrupted busy flag shows up in two ways. Status reads 1 too early, or a second launch pulse appears one cycle after a repeated launch write. Either can be caught on the next status read or on the next cycle. A wrong row decode puts data into the wrong 16-bit slice of `eng_grid` one cycle after the write, so the bench compares the whole vector against its own model after every access. A missed capture leaves the path read at a stale value on the first read after completion. A write that leaks through while busy changes `eng_ends` or `eng_grid` at once, while the engine is still running.

// File: rtl/plan_regbank_pkg.sv
package plan_regbank_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned OFS_GO  = 'h00;
   localparam int unsigned OFS_FIN = 'h04;
   localparam int unsigned OFS_END = 'h08;
   localparam int unsigned OFS_PTH = 'h0C;
   localparam int unsigned OFS_ROW = 'h10;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GO,
      SEL_FIN,
      SEL_END,
      SEL_PTH,
      SEL_ROW
   } sel_e;
endpackage

// File: rtl/plan_addr_dec.sv
module plan_addr_dec
   import plan_regbank_pkg::*;
#(
   parameter int unsigned ROWS  = 16,
   parameter int unsigned ROW_W = 4
) (
   input  logic [BUS_W-1:0] addr,
   output sel_e             sel,
   output logic [ROW_W-1:0] row_idx
);
   localparam int unsigned ROW_END = OFS_ROW + 4*ROWS;

   always_comb begin
      sel     = SEL_NONE;
      row_idx = '0;
      if (addr[1:0] == 2'b00) begin
         if (addr == OFS_GO)       sel = SEL_GO;
         else if (addr == OFS_FIN) sel = SEL_FIN;
         else if (addr == OFS_END) sel = SEL_END;
         else if (addr == OFS_PTH) sel = SEL_PTH;
         else if (addr >= OFS_ROW && addr < ROW_END) begin
            sel     = SEL_ROW;
            row_idx = ROW_W'((addr - OFS_ROW) >> 2);
         end
      end
   end
endmodule

// File: rtl/plan_run_ctl.sv
module plan_run_ctl #(
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_wr,
   input  logic             done_in,
   input  logic [RES_W-1:0] res_in,
   output logic             busy,
   output logic             fin,
   output logic             launch,
   output logic [RES_W-1:0] res_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         fin    <= 1'b0;
         launch <= 1'b0;
         res_q  <= '0;
      end else begin
         launch <= 1'b0;
         if (busy) begin
            if (done_in) begin
               busy  <= 1'b0;
               fin   <= 1'b1;
               res_q <= res_in;
            end
         end else if (go_wr) begin
            busy   <= 1'b1;
            fin    <= 1'b0;
            launch <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/plan_grid_store.sv
module plan_grid_store #(
   parameter int unsigned ROWS  = 16,
   parameter int unsigned COLS  = 16,
   parameter int unsigned ROW_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ROW_W-1:0]     idx,
   input  logic [COLS-1:0]      din,
   output logic [ROWS*COLS-1:0] grid
);
   for (genvar k = 0; k < ROWS; k++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n)
            grid[k*COLS +: COLS] <= '0;
         else if (wr && idx == ROW_W'(k))
            grid[k*COLS +: COLS] <= din;
      end
   end
endmodule

// File: rtl/plan_regbank.sv
module plan_regbank
   import plan_regbank_pkg::*;
#(
   parameter int unsigned ROWS  = 16,
   parameter int unsigned COLS  = 16,
   parameter int unsigned END_W = 16,
   parameter int unsigned RES_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [31:0]          addr,
   input  logic [31:0]          wdata,
   input  logic                 wr_en,
   input  logic                 rd_en,
   output logic [31:0]          rdata,
   output logic                 eng_launch,
   output logic [ROWS*COLS-1:0] eng_grid,
   output logic [END_W-1:0]     eng_ends,
   input  logic                 eng_done,
   input  logic [RES_W-1:0]     eng_path
);
   localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

   initial begin
      if (COLS > BUS_W || END_W > BUS_W || RES_W > BUS_W)
         $error("plan_regbank: field wider than bus");
      if (OFS_ROW + 4*ROWS > 256)
         $error("plan_regbank: row window too large");
   end

   sel_e             sel;
   logic [ROW_W-1:0] row_idx;
   logic             busy, fin;
   logic [RES_W-1:0] res_q;

   plan_addr_dec #(.ROWS(ROWS), .ROW_W(ROW_W)) u_dec (
      .addr(addr), .sel(sel), .row_idx(row_idx)
   );

   plan_run_ctl #(.RES_W(RES_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .go_wr(wr_en && sel == SEL_GO && wdata[0]),
      .done_in(eng_done), .res_in(eng_path),
      .busy(busy), .fin(fin), .launch(eng_launch), .res_q(res_q)
   );

   plan_grid_store #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_grid (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && !busy && sel == SEL_ROW),
      .idx(row_idx), .din(wdata[COLS-1:0]), .grid(eng_grid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         eng_ends <= '0;
      else if (wr_en && !busy && sel == SEL_END)
         eng_ends <= wdata[END_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en) begin
         case (sel)
            SEL_FIN: rdata <= {31'b0, fin};
            SEL_PTH: rdata <= 32'(res_q);
            default: rdata <= '0;
         endcase
      end else
         rdata <= '0;
   end
endmodule

// File: rtl/plan_regbank_chk.sv
module plan_regbank_chk #(
   parameter int unsigned ROWS  = 16,
   parameter int unsigned COLS  = 16,
   parameter int unsigned END_W = 16,
   parameter int unsigned RES_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [31:0]          addr,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [31:0]          rdata,
   input logic                 eng_launch,
   input logic [ROWS*COLS-1:0] eng_grid,
   input logic [END_W-1:0]     eng_ends,
   input logic                 eng_done,
   input logic                 busy
);
   a_r2_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |=> !eng_launch);
   a_r3_launch_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_launch) |-> busy);
   a_r7_grid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(eng_grid));
   a_r7_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(eng_ends));
   a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));
   a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr != 32'h4 && addr != 32'hC) |=> (rdata == '0));
endmodule

bind plan_regbank plan_regbank_chk #(
   .ROWS(ROWS), .COLS(COLS), .END_W(END_W), .RES_W(RES_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .rdata(rdata), .eng_launch(eng_launch), .eng_grid(eng_grid),
   .eng_ends(eng_ends), .eng_done(eng_done), .busy(busy)
);

// File: tb/sim_plan_regbank.sv
`timescale 1ns/1ps
module sim_plan_regbank;
   logic clk = 0, rst_n = 0;
   logic [31:0] addr = 0, wdata = 0, rdata, eng_path = 0;
   logic wr_en = 0, rd_en = 0, eng_launch, eng_done = 0;
   logic [255:0] eng_grid, m_grid;
   logic [15:0] eng_ends, m_ends;
   int checks = 0, fails = 0, launches = 0;
   logic m_busy;

   always #4 clk = ~clk;

   plan_regbank u0 (.*);

   always @(posedge clk) if (eng_launch) launches++;

   task automatic chk(input string r, input logic [255:0] act, exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0;
      if (!m_busy) begin
         if (a == 8) m_ends = d[15:0];
         else if (a >= 'h10 && a < 'h50 && a[1:0] == 0)
            m_grid[(a-'h10)/4*16 +: 16] = d[15:0];
      end
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] v);
      @(negedge clk); addr = a; rd_en = 1;
      @(negedge clk); rd_en = 0; v = rdata;
   endtask

   task automatic outs_ok(input string r);
      chk(r, eng_grid, m_grid);
      chk(r, {240'b0, eng_ends}, {240'b0, m_ends});
   endtask

   initial begin
      logic [31:0] v, p;
      int seed = 13, l0;
      m_grid = 0; m_ends = 0; m_busy = 0;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      rd(4, v); chk("R1 fin", v, 0);
      rd('hC, v); chk("R1 path", v, 0);
      chk("R1 launch", eng_launch, 0); outs_ok("R1");
      @(negedge clk); chk("R9 idle rdata", rdata, 0);
      for (int i = 0; i < 40; i++) begin
         logic [31:0] a = 32'h10 + 4*($urandom % 16);
         wr(a, $urandom); outs_ok("R5 row write");
      end
      wr('h4C, 32'hFFFF_1234); outs_ok("R5 last row");
      wr(8, 32'hABCD_5A3C); outs_ok("R6 ends");
      rd(8, v); chk("R8 ends read zero", v, 0);
      rd('h20, v); chk("R8 row read zero", v, 0);
      rd('h100, v); chk("R8 unmapped read", v, 0);
      wr('h100, 32'hFFFF_FFFF); wr('h12, 32'hFFFF_FFFF);
      wr(4, 1); wr('hC, 32'h55);
      outs_ok("R8 ignored writes");
      rd(4, v); chk("R8 fin unchanged", v, 0);
      rd('hC, v); chk("R8 path unchanged", v, 0);
      l0 = launches; wr(0, 0);
      chk("R2 zero write no launch", launches, l0);
      // launch
      @(negedge clk); addr = 0; wdata = 1; wr_en = 1;
      @(negedge clk); wr_en = 0; m_busy = 1;
      chk("R2 launch pulse", eng_launch, 1);
      @(negedge clk); chk("R2 pulse ends", eng_launch, 0);
      l0 = launches;
      wr(0, 1); chk("R3 relaunch ignored", launches, l0);
      rd(4, v); chk("R3 busy fin", v, 0);
      for (int i = 0; i < 10; i++) begin
         wr(32'h10 + 4*($urandom % 16), $urandom);
         wr(8, $urandom);
      end
      outs_ok("R7 busy writes");
      p = $urandom;
      @(negedge clk); eng_path = p; eng_done = 1;
      @(negedge clk); eng_done = 0; eng_path = ~p; m_busy = 0;
      rd(4, v); chk("R4 fin set", v, 1);
      rd('hC, v); chk("R4 path captured", v, p);
      rd('hC, v); chk("R4 path held", v, p);
      wr(8, 32'h1234); outs_ok("R6 write after done");
      // second run clears fin
      wr(0, 1); m_busy = 1;
      rd(4, v); chk("R3 fin cleared", v, 0);
      chk("R2 second launch", launches, l0 + 1);
      @(negedge clk); eng_path = 32'hCAFE_0001; eng_done = 1;
      @(negedge clk); eng_done = 0; m_busy = 0;
      rd('hC, v); chk("R4 second path", v, 32'hCAFE_0001);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule